// File: doc/BRIEF.md
# Packed Single-Precision Maximum Unit

This block takes two 128-bit operands, each holding four single-precision floating-point numbers, and returns the larger value of each lane pair in one 128-bit result. It reports whether any lane held a NaN (the invalid flag) and whether any lane held a subnormal value (the denormal flag). Both flags stay set until they are cleared. The operation does not commute: when either input is a NaN, or when both inputs are zero, the second operand's lane is returned unchanged. Callers rely on this to get a defined choice between the two operands.

One register stage sits between the inputs and the result. A small two-state controller tracks whether the result register holds a fresh answer. `ST_IDLE` means no result is due. `ST_EMIT` means the result and flags from the previous cycle's request are on the outputs. The transition `go` (from either state to `ST_EMIT`) happens on a cycle with `in_vld` high. The transition `rest` (from either state to `ST_IDLE`) happens on a cycle with `in_vld` low. Reset forces `ST_IDLE`.

Top module: `pmax_unit`

## Requirements
- R1: Lane k (k = 0..3) occupies bits [32k+31:32k] of `opa`, `opb` and `res`, and each lane is computed independently of the others.
- R2: For non-NaN inputs, a lane of `res` equals the `opa` lane when that value is strictly greater than the `opb` lane, and equals the `opb` lane otherwise.
- R3: Ordering follows numeric value: -0 and +0 compare equal, and negative values are below positive ones. Infinities are the extremes, and subnormals (exponent field 0, fraction non-zero) are compared by their exact value with no flush to zero.
- R4: If either lane input is a NaN (exponent field all ones, fraction non-zero), the `opb` lane is returned bit for bit, including its sign and payload.
- R5: If both lane inputs are zero of any sign, the `opb` lane is returned bit for bit.
- R6: `flag_inv` is set when any lane of an accepted request has a NaN in either operand, whether quiet or signaling.
- R7: `flag_den` is set when any lane of an accepted request has a subnormal in either operand.
- R8: A request with `in_vld` high produces `res` and `res_vld` high exactly one cycle later. When `in_vld` is low, `res_vld` drops the next cycle and `res` holds its value.
- R9: Both flags are sticky. `flag_clr` clears them at the next edge, but a flag raised by a request in the same cycle as the clear still ends up set.
- R10: Reset (active-low `rst_n`) clears `res_vld`, `res`, `flag_inv` and `flag_den`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request strobe: operands are taken this cycle |
| opa | input | 128 | First operand, four lanes |
| opb | input | 128 | Second operand, four lanes |
| flag_clr | input | 1 | Clears the sticky flags |
| res_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| res | output | 128 | Per-lane maximum |
| flag_inv | output | 1 | Sticky: a NaN was seen |
| flag_den | output | 1 | Sticky: a subnormal was seen |

## Verification
Every result, its strobe and the flags it raises are due on the first rising edge after the cycle in which `in_vld` was high. The bench changes inputs on falling edges and reads outputs on the next falling edge, half a period after the edge that loads them. Each sweep vector pulses `flag_clr` together with its request, so the flags read back reflect that vector alone. Separate sequences check that the flags stay sticky over idle and clean requests, and that `res` holds between requests.

// File: rtl/pmax_pkg.sv
package pmax_pkg;
    parameter int unsigned EXP_W  = 8;
    parameter int unsigned MAN_W  = 23;
    parameter int unsigned WORD_W = 1 + EXP_W + MAN_W;

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] ex;
        logic [MAN_W-1:0] man;
    } fp_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/pmax_lane.sv
module pmax_lane
    import pmax_pkg::*;
(
    input  fp_t  a,
    input  fp_t  b,
    output fp_t  y,
    output logic nan_any,
    output logic den_any
);
    logic a_nan, b_nan, a_den, b_den, a_zero, b_zero;
    logic mag_gt, mag_lt, a_gt;

    always_comb begin
        a_nan  = (&a.ex) && (|a.man);
        b_nan  = (&b.ex) && (|b.man);
        a_den  = (a.ex == '0) && (|a.man);
        b_den  = (b.ex == '0) && (|b.man);
        a_zero = ({a.ex, a.man} == '0);
        b_zero = ({b.ex, b.man} == '0);
        mag_gt = {a.ex, a.man} > {b.ex, b.man};
        mag_lt = {a.ex, a.man} < {b.ex, b.man};

        if (a_nan || b_nan || (a_zero && b_zero))
            a_gt = 1'b0;
        else if (a.sgn != b.sgn)
            a_gt = !a.sgn;
        else if (!a.sgn)
            a_gt = mag_gt;
        else
            a_gt = mag_lt;

        y       = a_gt ? a : b;
        nan_any = a_nan || b_nan;
        den_any = a_den || b_den;
    end
endmodule

// File: rtl/pmax_sticky.sv
module pmax_sticky #(
    parameter int unsigned NBITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set_en,
    input  logic [NBITS-1:0] set_val,
    output logic [NBITS-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= (q & ~{NBITS{clr}}) | (set_val & {NBITS{set_en}});
    end
endmodule

// File: rtl/pmax_unit.sv
module pmax_unit
    import pmax_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned BUS_W = LANES * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [BUS_W-1:0] opa,
    input  logic [BUS_W-1:0] opb,
    input  logic             flag_clr,
    output logic             res_vld,
    output logic [BUS_W-1:0] res,
    output logic             flag_inv,
    output logic             flag_den
);
    ctl_state_e        st_q, st_d;
    logic [BUS_W-1:0]  lane_y;
    logic [LANES-1:0]  lane_nan, lane_den;
    logic [BUS_W-1:0]  res_q;
    logic [1:0]        flg_q;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        fp_t y_k;
        pmax_lane u_lane (
            .a       (fp_t'(opa[k*WORD_W +: WORD_W])),
            .b       (fp_t'(opb[k*WORD_W +: WORD_W])),
            .y       (y_k),
            .nan_any (lane_nan[k]),
            .den_any (lane_den[k])
        );
        assign lane_y[k*WORD_W +: WORD_W] = y_k;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions: go / rest
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = in_vld ? ST_EMIT : ST_IDLE;
            ST_EMIT: st_d = in_vld ? ST_EMIT : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      res_q <= '0;
        else if (in_vld) res_q <= lane_y;
    end

    pmax_sticky #(.NBITS(2)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flag_clr),
        .set_en  (in_vld),
        .set_val ({|lane_den, |lane_nan}),
        .q       (flg_q)
    );

    // outputs
    always_comb begin
        res_vld  = (st_q == ST_EMIT);
        res      = res_q;
        flag_inv = flg_q[0];
        flag_den = flg_q[1];
    end
endmodule

// File: rtl/pmax_unit_chk.sv
module pmax_unit_chk #(
    parameter int unsigned BUS_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [BUS_W-1:0] opa,
    input logic [BUS_W-1:0] opb,
    input logic             flag_clr,
    input logic             res_vld,
    input logic [BUS_W-1:0] res,
    input logic             flag_inv,
    input logic             flag_den
);
    assert_vld_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> res_vld);
    assert_vld_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !res_vld);
    assert_res_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(res));
    assert_nan_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (&opa[30:23]) && (|opa[22:0]))
        |=> (res[31:0] == $past(opb[31:0])) && flag_inv);
    assert_zero_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && opa[30:0] == '0 && opb[30:0] == '0)
        |=> res[31:0] == $past(opb[31:0]));
    assert_den_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && opb[30:23] == '0 && (|opb[22:0])) |=> flag_den);
    assert_inv_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_inv && !flag_clr) |=> flag_inv);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !in_vld) |=> (!flag_inv && !flag_den));
endmodule

bind pmax_unit pmax_unit_chk #(.BUS_W(BUS_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opa(opa), .opb(opb),
    .flag_clr(flag_clr), .res_vld(res_vld), .res(res),
    .flag_inv(flag_inv), .flag_den(flag_den)
);

// File: tb/test_pmax_unit.sv
module test_pmax_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic         flag_clr = 1'b0;
    logic         res_vld;
    logic [127:0] res;
    logic         flag_inv, flag_den;
    int           total = 0;
    int           bad = 0;
    bit           done = 0;

    always #2 clk = ~clk;

    pmax_unit i_pmax_unit (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opa(opa), .opb(opb),
        .flag_clr(flag_clr), .res_vld(res_vld), .res(res),
        .flag_inv(flag_inv), .flag_den(flag_den)
    );

    function automatic logic [31:0] pick(input int i);
        case (i % 16)
            0: return 32'h0000_0000;  1: return 32'h8000_0000;
            2: return 32'h0000_0001;  3: return 32'h007f_ffff;
            4: return 32'h807f_fffe;  5: return 32'h3f80_0000;
            6: return 32'hbf80_0000;  7: return 32'h4000_0000;
            8: return 32'hc000_0000;  9: return 32'h7f7f_ffff;
            10: return 32'h7f80_0000; 11: return 32'hff80_0000;
            12: return 32'h7fc0_0000; 13: return 32'h7f80_0001;
            14: return 32'hffc1_2345; default: return 32'h0080_0000;
        endcase
    endfunction

    function automatic bit is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hff) && (x[22:0] != 0);
    endfunction
    function automatic bit is_den(input logic [31:0] x);
        return (x[30:23] == 8'h00) && (x[22:0] != 0);
    endfunction
    function automatic real to_real(input logic [31:0] x);
        real m;
        int  e;
        e = int'(x[30:23]);
        if (e == 255)    m = 1.0e300;
        else if (e == 0) m = real'(x[22:0]) * (2.0 ** (-149));
        else             m = (real'(x[22:0]) + 8388608.0) * (2.0 ** (e - 150));
        return x[31] ? -m : m;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [127:0] a, input logic [127:0] b, input bit clr);
        logic [127:0] er;
        bit ei, ed;
        ei = 0; ed = 0;
        @(negedge clk);
        opa = a; opb = b; in_vld = 1; flag_clr = clr;
        @(negedge clk);
        in_vld = 0; flag_clr = 0;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] la, lb;
            string tg;
            la = a[k*32 +: 32]; lb = b[k*32 +: 32];
            ei |= is_nan(la) || is_nan(lb);
            ed |= is_den(la) || is_den(lb);
            if (is_nan(la) || is_nan(lb)) begin er[k*32 +: 32] = lb; tg = "R4"; end
            else if (la[30:0] == 0 && lb[30:0] == 0) begin er[k*32 +: 32] = lb; tg = "R5"; end
            else if (to_real(la) > to_real(lb)) begin er[k*32 +: 32] = la; tg = "R2"; end
            else begin er[k*32 +: 32] = lb; tg = "R3"; end
            check($sformatf("%s R1 lane%0d a=%h b=%h", tg, k, la, lb),
                  {96'b0, res[k*32 +: 32]}, {96'b0, er[k*32 +: 32]});
        end
        check("R8 res_vld after request", {127'b0, res_vld}, 128'd1);
        if (clr) begin
            check("R6 flag_inv", {127'b0, flag_inv}, {127'b0, ei});
            check("R7 flag_den", {127'b0, flag_den}, {127'b0, ed});
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 res_vld reset", {127'b0, res_vld}, 128'd0);
        check("R10 res reset", res, 128'd0);
        check("R10 flags reset", {126'b0, flag_inv, flag_den}, 128'd0);
        rst_n = 1;

        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                run_vec({pick(i), pick(i + 1), pick(j), pick(i)},
                        {pick(j + 3), pick(j), pick(i), pick(j)}, 1'b1);

        // R8: idle cycle drops strobe and holds result
        begin
            logic [127:0] held;
            held = res;
            @(negedge clk);
            check("R8 res_vld idle", {127'b0, res_vld}, 128'd0);
            check("R8 res held", res, held);
        end

        // R9: sticky behaviour
        run_vec({4{32'h7fc0_0000}}, {4{32'h0000_0001}}, 1'b1);
        run_vec({4{32'h3f80_0000}}, {4{32'h4000_0000}}, 1'b0);
        check("R9 inv stays set", {127'b0, flag_inv}, 128'd1);
        check("R9 den stays set", {127'b0, flag_den}, 128'd1);
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        check("R9 clear", {126'b0, flag_inv, flag_den}, 128'd0);
        run_vec({4{32'h3f80_0000}}, {4{32'h4000_0000}}, 1'b1);
        check("R9 clean request sets nothing", {126'b0, flag_inv, flag_den}, 128'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule